// File: doc/BRIEF.md
# Masked Comma Detector and Aligner

This block sits after a deserializer that delivers one 10-bit parallel word per clock with no knowledge of where symbol boundaries fall. It watches the received bit stream for a programmable plus comma or minus comma. A per-bit mask turns selected pattern bits into don't-care positions, so partial patterns can match. When a comma is found at some bit offset, the block latches that offset and barrel-shifts every following word, so that the comma and the data after it come out on word boundaries.

A double mode requires a minus comma followed at once by a plus comma, read as one 20-bit sequence. This suits framing schemes built on two back-to-back framing bytes. When the enable input is low, the search and the shifter are skipped and the input word goes to the output combinationally.

Top module: `comma_align`

## Requirements
- R1: While reset is held and the block is enabled, `dout`, `comma_det` and `align_chg` are all zero. The held offset clears to 0, so with no comma the output is the unshifted stream.
- R2: With `align_en` low, `dout` equals `din` in the same cycle, and `comma_det` and `align_chg` are low.
- R3: A candidate c matches pattern p under mask m when every bit i with m[i]=1 has c[i]=p[i]; bits with m[i]=0 are don't-care. Bit 0 of every word and candidate is the earliest received bit. For example, mask 0001111111 with pattern 0101111100 requires only the low seven bits to be 1111100.
- R4: In single mode (`double_en` low), a candidate matching either `plus_pat` or `minus_pat` counts as a comma.
- R5: In double mode, detection needs a 20-bit span whose earlier 10 bits match `minus_pat` and whose later 10 bits match `plus_pat`. A lone plus comma is not detected.
- R6: At each clock edge with offset k, `dout` becomes bits k..k+9 of the 20-bit value {current `din`, previous `din`}, where the previous word forms the low half. The candidate that is checked (the later one in double mode) is this same span.
- R7: `comma_det` is high in exactly the cycle in which `dout` shows the matched comma word, and only when enabled.
- R8: If several offsets match in one cycle, the lowest offset is taken.
- R9: `align_chg` pulses for one cycle with `comma_det` only when the taken offset differs from the one previously held.
- R10: The offset is held while no comma is detected, and while bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| align_en | input | 1 | High: search and align; low: bypass |
| double_en | input | 1 | High: require minus then plus comma |
| plus_pat | input | 10 | Plus comma pattern |
| minus_pat | input | 10 | Minus comma pattern |
| pat_mask | input | 10 | Per-bit compare enable, 1 = compare |
| din | input | 10 | Unaligned received word |
| dout | output | 10 | Aligned (or bypassed) word |
| comma_det | output | 1 | Comma present in current `dout` |
| align_chg | output | 1 | Offset changed on this detection |

## Verification
The hardest case to reach is one where several bit offsets match in the same cycle, so that only the lowest-offset rule decides the result. Random words almost never produce that case under a full mask. The stimulus therefore drops the mask to a few bits or to all zeros, which lets many offsets hit at once. It also injects commas at chosen offsets inside random surrounding bits, and moves the offset so that the change pulse and the hold behaviour are exercised. The double-mode reject case is driven directly: a lone plus comma is sent and no detection may follow.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;
    typedef enum logic {
        SRCH_SINGLE = 1'b0,
        SRCH_DOUBLE = 1'b1
    } srch_mode_e;
endpackage

// File: rtl/comma_match.sv
module comma_match #(
    parameter int unsigned WORD_W = 10
) (
    input  logic [WORD_W-1:0] cand,
    input  logic [WORD_W-1:0] pat,
    input  logic [WORD_W-1:0] mask,
    output logic              hit
);
    // Only bits enabled in the mask take part in the compare.
    assign hit = ~|((cand ^ pat) & mask);
endmodule

// File: rtl/comma_search.sv
module comma_search
    import comma_align_pkg::*;
#(
    parameter int unsigned WORD_W = 10,
    localparam int unsigned OFF_W = $clog2(WORD_W),
    localparam int unsigned WIN_W = 3 * WORD_W
) (
    input  logic [WIN_W-1:0]  win,
    input  logic [WORD_W-1:0] plus_pat,
    input  logic [WORD_W-1:0] minus_pat,
    input  logic [WORD_W-1:0] pat_mask,
    input  srch_mode_e        mode,
    output logic              hit,
    output logic [OFF_W-1:0]  sel_off
);
    logic [WORD_W-1:0] match_vec;

    for (genvar k = 0; k < WORD_W; k++) begin : g_off
        logic [WORD_W-1:0] early_w;
        logic [WORD_W-1:0] late_w;
        logic              late_plus;
        logic              late_minus;
        logic              early_minus;

        assign early_w = win[k +: WORD_W];
        assign late_w  = win[k + WORD_W +: WORD_W];

        comma_match #(.WORD_W(WORD_W)) u_lp (
            .cand(late_w), .pat(plus_pat), .mask(pat_mask), .hit(late_plus)
        );
        comma_match #(.WORD_W(WORD_W)) u_lm (
            .cand(late_w), .pat(minus_pat), .mask(pat_mask), .hit(late_minus)
        );
        comma_match #(.WORD_W(WORD_W)) u_em (
            .cand(early_w), .pat(minus_pat), .mask(pat_mask), .hit(early_minus)
        );

        always_comb begin
            if (mode == SRCH_DOUBLE) begin
                match_vec[k] = early_minus & late_plus;
            end else begin
                match_vec[k] = late_plus | late_minus;
            end
        end
    end

    // Priority encoder: the lowest matching offset wins.
    always_comb begin
        sel_off = '0;
        for (int k = WORD_W - 1; k >= 0; k--) begin
            if (match_vec[k]) begin
                sel_off = OFF_W'(k);
            end
        end
        hit = |match_vec;
    end

    // R8: the offset chosen is a matching one and no lower offset matched.
    always_comb begin
        if (hit) begin
            p_sel_lowest_r8: assert (match_vec[sel_off] &&
                ((match_vec & ((WORD_W'(1) << sel_off) - WORD_W'(1))) == '0));
        end
    end
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
    parameter int unsigned WORD_W = 10,
    localparam int unsigned OFF_W = $clog2(WORD_W)
) (
    input  logic [2*WORD_W-1:0] pair,
    input  logic [OFF_W-1:0]    off,
    output logic [WORD_W-1:0]   word
);
    assign word = pair[off +: WORD_W];
endmodule

// File: rtl/comma_align.sv
module comma_align
    import comma_align_pkg::*;
#(
    parameter int unsigned WORD_W = 10,
    localparam int unsigned OFF_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              align_en,
    input  logic              double_en,
    input  logic [WORD_W-1:0] plus_pat,
    input  logic [WORD_W-1:0] minus_pat,
    input  logic [WORD_W-1:0] pat_mask,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              comma_det,
    output logic              align_chg
);
    typedef struct packed {
        logic [WORD_W-1:0] prev1;
        logic [WORD_W-1:0] prev2;
        logic [WORD_W-1:0] word;
        logic [OFF_W-1:0]  off;
        logic              det;
        logic              chg;
    } state_t;

    state_t            st_d, st_q;
    logic              hit;
    logic [OFF_W-1:0]  hit_off;
    logic [OFF_W-1:0]  use_off;
    logic [WORD_W-1:0] shifted;
    srch_mode_e        mode;

    assign mode    = double_en ? SRCH_DOUBLE : SRCH_SINGLE;
    assign use_off = hit ? hit_off : st_q.off;

    comma_search #(.WORD_W(WORD_W)) u_search (
        .win      ({din, st_q.prev1, st_q.prev2}),
        .plus_pat (plus_pat),
        .minus_pat(minus_pat),
        .pat_mask (pat_mask),
        .mode     (mode),
        .hit      (hit),
        .sel_off  (hit_off)
    );

    word_shifter #(.WORD_W(WORD_W)) u_shift (
        .pair({din, st_q.prev1}),
        .off (use_off),
        .word(shifted)
    );

    always_comb begin
        st_d       = st_q;
        st_d.prev1 = din;
        st_d.prev2 = st_q.prev1;
        st_d.det   = 1'b0;
        st_d.chg   = 1'b0;
        if (align_en) begin
            st_d.word = shifted;
            if (hit) begin
                st_d.off = hit_off;
                st_d.det = 1'b1;
                st_d.chg = (hit_off != st_q.off);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout      = align_en ? st_q.word : din;
    assign comma_det = align_en & st_q.det;
    assign align_chg = align_en & st_q.chg;

    // R9: a change pulse only comes with a detection.
    p_chg_needs_det_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.chg |-> st_q.det);

    // R9: a change pulse means the held offset really moved.
    p_chg_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.chg |-> (st_q.off != $past(st_q.off)));

    // R10: no detection while enabled, or bypass, keeps the offset.
    p_off_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(align_en && hit) |=> $stable(st_q.off));

    // R7: a registered detection comes only from an enabled cycle.
    p_det_follows_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.det |-> $past(align_en));
endmodule

// File: tb/comma_align_tb_top.sv
`timescale 1ns/1ps
module comma_align_tb_top;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         align_en = 1'b1;
    logic         double_en = 1'b0;
    logic [W-1:0] plus_pat = 10'b0011111010;
    logic [W-1:0] minus_pat = 10'b1100000101;
    logic [W-1:0] pat_mask = '1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         comma_det;
    logic         align_chg;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [W-1:0] m_p1 = '0;
    logic [W-1:0] m_p2 = '0;
    int           m_off = 0;

    always #10 clk = ~clk;

    comma_align #(.WORD_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .align_en(align_en), .double_en(double_en),
        .plus_pat(plus_pat), .minus_pat(minus_pat), .pat_mask(pat_mask),
        .din(din), .dout(dout), .comma_det(comma_det), .align_chg(align_chg)
    );

    function automatic bit mok(logic [W-1:0] c, logic [W-1:0] p, logic [W-1:0] m);
        for (int i = 0; i < W; i++) begin
            if (m[i] && (c[i] !== p[i])) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // One clock of stimulus plus the expected response.
    task automatic step(string tag, logic [W-1:0] w);
        logic [3*W-1:0] win;
        logic [2*W-1:0] pr;
        int  found;
        bit  e_det, e_chg;
        logic [W-1:0] e_dout;
        @(negedge clk);
        din = w;
        #1;
        if (!align_en) begin
            chk("R2", "bypass dout", dout, din);
            chk("R2", "bypass det", {9'b0, comma_det}, '0);
            chk("R2", "bypass chg", {9'b0, align_chg}, '0);
        end
        win = {w, m_p1, m_p2};
        pr  = {w, m_p1};
        found = -1;
        e_det = 1'b0;
        e_chg = 1'b0;
        if (align_en) begin
            for (int k = 0; k < W && found < 0; k++) begin
                logic [W-1:0] lo, hi;
                lo = win[k +: W];
                hi = win[k + W +: W];
                if (double_en) begin
                    if (mok(lo, minus_pat, pat_mask) && mok(hi, plus_pat, pat_mask)) found = k;
                end else begin
                    if (mok(hi, plus_pat, pat_mask) || mok(hi, minus_pat, pat_mask)) found = k;
                end
            end
            if (found >= 0) begin
                e_det = 1'b1;
                e_chg = (found != m_off);
                m_off = found;
            end
        end
        e_dout = pr[m_off +: W];
        m_p2 = m_p1;
        m_p1 = w;
        @(posedge clk);
        #1;
        if (align_en) begin
            chk(tag, "dout R6", dout, e_dout);
            chk(tag, "det R7", {9'b0, comma_det}, {9'b0, e_det});
            chk(tag, "chg R9", {9'b0, align_chg}, {9'b0, e_chg});
        end
    endtask

    // Place pattern bits at offset k inside random surrounding words.
    task automatic inject(string tag, int k, bit dbl);
        logic [3*W-1:0] b;
        b = {$urandom(), $urandom()};
        if (dbl) b[k +: 2*W] = {plus_pat, minus_pat};
        else     b[k + W +: W] = ($urandom_range(1) != 0) ? plus_pat : minus_pat;
        step(tag, b[W-1:0]);
        step(tag, b[2*W-1:W]);
        step(tag, b[3*W-1:2*W]);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        #5;
        chk("R1", "reset dout", dout, '0);
        chk("R1", "reset det", {9'b0, comma_det}, '0);
        chk("R1", "reset chg", {9'b0, align_chg}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: offset 0 after reset, stream passes unshifted.
        for (int i = 0; i < 4; i++) step("R1", 10'h155);

        // R4: single comma at several offsets, both polarities.
        for (int k = 0; k < W; k++) inject("R4", k, 1'b0);

        // R3: masked partial match as in the worked example.
        pat_mask  = 10'b0001111111;
        plus_pat  = 10'b0101111100;
        minus_pat = 10'b0101111100;
        step("R3", 10'b1111111100);
        step("R3", 10'b0000000000);
        step("R3", 10'b1011111100);
        step("R3", 10'b0000000000);

        // R5: double mode; lone plus comma, then a true pair.
        plus_pat  = 10'b0011111010;
        minus_pat = 10'b1100000101;
        pat_mask  = '1;
        double_en = 1'b1;
        step("R5", 10'h000);
        step("R5", 10'h000);
        step("R5", plus_pat);
        step("R5", 10'h000);
        step("R5", 10'h000);
        inject("R5", 4, 1'b1);
        inject("R5", 0, 1'b1);
        double_en = 1'b0;

        // R8: empty mask makes every offset match at once.
        inject("R10", 6, 1'b0);
        pat_mask = '0;
        for (int i = 0; i < 3; i++) step("R8", 10'(($urandom())));
        pat_mask = '1;

        // R10: offset survives a stretch of bypass.
        inject("R10", 7, 1'b0);
        align_en = 1'b0;
        for (int i = 0; i < 5; i++) step("R2", 10'(($urandom())));
        align_en = 1'b1;
        for (int i = 0; i < 4; i++) step("R10", 10'h155);

        // Random mixture.
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(99);
            if (r < 3) align_en = ~align_en;
            else if (r < 6) double_en = ~double_en;
            else if (r < 8) pat_mask = 10'(($urandom()));
            else if (r < 10) pat_mask = '1;
            if (r >= 60 && r < 85) inject("R6", $urandom_range(W - 1), double_en);
            else step("R6", 10'(($urandom())));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule